// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit processor's load/store unit and a 32-bit data bus with big-endian byte numbering. For a load it turns the raw bus word into the value for the destination register: a byte access picks one lane and zero-extends it, and a word access rotates the bus word by the byte offset. Misaligned word loads do not fault. For a store it forms the word to drive onto the write bus. A byte store copies the low byte into every lane, and a word store passes the source through unchanged.

When the stored register is the program counter, the block substitutes the current instruction address plus twelve for the source value. Results are registered. A valid flag marks the cycle after each accepted request, and the outputs hold until the next request.

Top module: `be_data_aligner`

## Requirements
- R1: For a byte load (`req_kind` = 2'b00), result bits 7:0 come from bus bits 31:24 at offset 0, 23:16 at offset 1, 15:8 at offset 2 and 7:0 at offset 3.
- R2: A byte load returns zeros in result bits 31:8.
- R3: For a word load (`req_kind` = 2'b01), the result is the bus word rotated right by 8 × offset. This puts the addressed byte at bits 31:24 for offsets 0 and 2, and at bits 15:8 for offsets 1 and 3.
- R4: For a byte store (`req_kind` = 2'b10), each of the four write-bus lanes carries bits 7:0 of the store source, at every offset.
- R5: For a word store (`req_kind` = 2'b11), the write bus equals the store source bit for bit, at every offset.
- R6: When `st_src_is_pc` is 1 on a store, the store source used is `instr_addr` + 12, and `st_src` is ignored.
- R7: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and 0 otherwise.
- R8: In a cycle after one with `req_valid` = 0, `ld_result` and `wr_bus` keep their previous values.
- R9: A synchronous active-high `rst` clears `ld_result`, `wr_bus` and `out_valid` to zero.
- R10: A load request drives `wr_bus` to zero, and a store request drives `ld_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request accepted this cycle |
| req_kind | input | 2 | 00 byte load, 01 word load, 10 byte store, 11 word store |
| req_offset | input | 2 | Low two address bits |
| rd_bus | input | 32 | Read data bus word |
| st_src | input | 32 | Store source register value |
| st_src_is_pc | input | 1 | Store source is the program counter |
| instr_addr | input | 32 | Address of the current instruction |
| ld_result | output | 32 | Value for the destination register |
| wr_bus | output | 32 | Word for the write data bus |
| out_valid | output | 1 | Result valid, one cycle after a request |

## Verification
Capturing a new request and presenting the previous result happen in the same cycle whenever requests arrive back to back. The bench therefore streams unbroken runs of mixed loads and stores. Each output word must match the request from one cycle earlier, never the one currently on the inputs. Stores of the program counter also mix address arithmetic with byte replication in one cycle. These are judged on the low byte of instruction address plus twelve appearing in all four lanes, while the `st_src` value supplied alongside does not appear.

// File: rtl/bal_pkg.sv
package bal_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = XLEN / BYTE_W;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [OFF_W-1:0] offs_t;

    typedef enum logic [1:0] {
        ACC_LD_BYTE = 2'b00,
        ACC_LD_WORD = 2'b01,
        ACC_ST_BYTE = 2'b10,
        ACC_ST_WORD = 2'b11
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        offs_t     offset;
        word_t     rd_bus;
        word_t     store_src;
    } acc_req_t;

    typedef struct packed {
        word_t ld_value;
        word_t wr_word;
    } acc_rsp_t;

    function automatic logic kind_is_store(acc_kind_e k);
        return k[1];
    endfunction

    function automatic logic kind_is_word(acc_kind_e k);
        return k[0];
    endfunction
endpackage

// File: rtl/bal_load_path.sv
module bal_load_path
    import bal_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned LN_W   = BYTE_W,
    localparam int unsigned NLANE = DATA_W / LN_W,
    localparam int unsigned SEL_W = $clog2(NLANE)
) (
    input  logic              word_access,
    input  logic [SEL_W-1:0]  offset,
    input  logic [DATA_W-1:0] bus_word,
    output logic [DATA_W-1:0] ld_value
);
    logic [LN_W-1:0]   lane   [NLANE];
    logic [DATA_W-1:0] rotated[NLANE];

    genvar gi;
    generate
        for (gi = 0; gi < NLANE; gi++) begin : g_lane
            // big-endian: lane index 0 is the most significant byte
            assign lane[gi] = bus_word[DATA_W-1-LN_W*gi -: LN_W];
            if (gi == 0) begin : g_rot0
                assign rotated[gi] = bus_word;
            end else begin : g_rotn
                assign rotated[gi] = {bus_word[LN_W*gi-1:0], bus_word[DATA_W-1:LN_W*gi]};
            end
        end
    endgenerate

    always_comb begin
        if (word_access) begin
            ld_value = rotated[offset];
        end else begin
            ld_value = '0;
            ld_value[LN_W-1:0] = lane[offset];
        end
    end
endmodule

// File: rtl/bal_store_path.sv
module bal_store_path
    import bal_pkg::*;
#(
    parameter int unsigned DATA_W   = XLEN,
    parameter int unsigned LN_W     = BYTE_W,
    parameter int unsigned PC_AHEAD = 12,
    localparam int unsigned NLANE   = DATA_W / LN_W
) (
    input  logic              word_access,
    input  logic              src_is_pc,
    input  logic [DATA_W-1:0] src_value,
    input  logic [DATA_W-1:0] instr_addr,
    output logic [DATA_W-1:0] wr_word
);
    logic [DATA_W-1:0] eff_src;
    logic [DATA_W-1:0] replicated;

    assign eff_src = src_is_pc ? (instr_addr + DATA_W'(PC_AHEAD)) : src_value;

    genvar gi;
    generate
        for (gi = 0; gi < NLANE; gi++) begin : g_rep
            assign replicated[LN_W*gi +: LN_W] = eff_src[LN_W-1:0];
        end
    endgenerate

    assign wr_word = word_access ? eff_src : replicated;
endmodule

// File: rtl/bal_out_reg.sv
module bal_out_reg
    import bal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  acc_rsp_t next_rsp,
    output acc_rsp_t held_rsp,
    output logic     held_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_rsp   <= '0;
            held_valid <= 1'b0;
        end else begin
            held_valid <= capture;
            if (capture) begin
                held_rsp <= next_rsp;
            end
        end
    end
endmodule

// File: rtl/be_data_aligner.sv
module be_data_aligner
    import bal_pkg::*;
#(
    parameter int unsigned PC_AHEAD = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [XLEN-1:0]  rd_bus,
    input  logic [XLEN-1:0]  st_src,
    input  logic             st_src_is_pc,
    input  logic [XLEN-1:0]  instr_addr,
    output logic [XLEN-1:0]  ld_result,
    output logic [XLEN-1:0]  wr_bus,
    output logic             out_valid
);
    acc_req_t req;
    acc_rsp_t next_rsp;
    acc_rsp_t held_rsp;
    word_t    load_val;
    word_t    store_val;

    assign req.kind      = acc_kind_e'(req_kind);
    assign req.offset    = req_offset;
    assign req.rd_bus    = rd_bus;
    assign req.store_src = st_src;

    bal_load_path #(.DATA_W(XLEN), .LN_W(BYTE_W)) u_load (
        .word_access (kind_is_word(req.kind)),
        .offset      (req.offset),
        .bus_word    (req.rd_bus),
        .ld_value    (load_val)
    );

    bal_store_path #(.DATA_W(XLEN), .LN_W(BYTE_W), .PC_AHEAD(PC_AHEAD)) u_store (
        .word_access (kind_is_word(req.kind)),
        .src_is_pc   (st_src_is_pc),
        .src_value   (req.store_src),
        .instr_addr  (instr_addr),
        .wr_word     (store_val)
    );

    always_comb begin
        if (kind_is_store(req.kind)) begin
            next_rsp.ld_value = '0;
            next_rsp.wr_word  = store_val;
        end else begin
            next_rsp.ld_value = load_val;
            next_rsp.wr_word  = '0;
        end
    end

    bal_out_reg u_oreg (
        .clk        (clk),
        .rst        (rst),
        .capture    (req_valid),
        .next_rsp   (next_rsp),
        .held_rsp   (held_rsp),
        .held_valid (out_valid)
    );

    assign ld_result = held_rsp.ld_value;
    assign wr_bus    = held_rsp.wr_word;
endmodule

module be_data_aligner_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic [31:0] st_src,
    input logic        st_src_is_pc,
    input logic [31:0] ld_result,
    input logic [31:0] wr_bus,
    input logic        out_valid
);
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(ld_result) && $stable(wr_bus)));
    a_r2_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b00) |=> (ld_result[31:8] == 24'd0));
    a_r4_replicate: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b10) |=>
        (wr_bus[31:24] == wr_bus[7:0] && wr_bus[23:16] == wr_bus[7:0] && wr_bus[15:8] == wr_bus[7:0]));
    a_r5_word_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b11 && !st_src_is_pc) |=> (wr_bus == $past(st_src)));
    a_r10_store_no_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind[1]) |=> (ld_result == 32'd0));
    a_r10_load_no_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kind[1]) |=> (wr_bus == 32'd0));
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && ld_result == 32'd0 && wr_bus == 32'd0));
endmodule

bind be_data_aligner be_data_aligner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .st_src       (st_src),
    .st_src_is_pc (st_src_is_pc),
    .ld_result    (ld_result),
    .wr_bus       (wr_bus),
    .out_valid    (out_valid)
);

// File: tb/tb_be_data_aligner.sv
module tb_be_data_aligner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [1:0]  req_offset = 2'b00;
    logic [31:0] rd_bus = '0;
    logic [31:0] st_src = '0;
    logic        st_src_is_pc = 1'b0;
    logic [31:0] instr_addr = '0;
    logic [31:0] ld_result;
    logic [31:0] wr_bus;
    logic        out_valid;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;
    bit          hold_mode = 1'b0;

    typedef struct {
        logic [31:0] ld;
        logic [31:0] wr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] last_ld = '0;
    logic [31:0] last_wr = '0;

    always #4 clk = ~clk;

    be_data_aligner dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_offset(req_offset), .rd_bus(rd_bus), .st_src(st_src),
        .st_src_is_pc(st_src_is_pc), .instr_addr(instr_addr),
        .ld_result(ld_result), .wr_bus(wr_bus), .out_valid(out_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] k, input logic [1:0] off,
                                   input logic [31:0] rd, input logic [31:0] src,
                                   input logic pc, input logic [31:0] ia);
        exp_t e;
        logic [31:0] s;
        s = pc ? ia + 32'd12 : src;
        e.ld = '0; e.wr = '0;
        case (k)
            2'b00: begin
                e.tag = "R1/R2 byte load";
                case (off)
                    2'd0: e.ld = {24'd0, rd[31:24]};
                    2'd1: e.ld = {24'd0, rd[23:16]};
                    2'd2: e.ld = {24'd0, rd[15:8]};
                    default: e.ld = {24'd0, rd[7:0]};
                endcase
            end
            2'b01: begin
                e.tag = "R3 word load";
                case (off)
                    2'd0: e.ld = rd;
                    2'd1: e.ld = {rd[7:0], rd[31:8]};
                    2'd2: e.ld = {rd[15:0], rd[31:16]};
                    default: e.ld = {rd[23:0], rd[31:24]};
                endcase
            end
            2'b10: begin
                e.tag = pc ? "R6 pc byte store" : "R4 byte store";
                e.wr = {4{s[7:0]}};
            end
            default: begin
                e.tag = pc ? "R6 pc word store" : "R5 word store";
                e.wr = s;
            end
        endcase
        return e;
    endfunction

    task automatic send(input logic [1:0] k, input logic [1:0] off, input logic [31:0] rd,
                        input logic [31:0] src, input logic pc, input logic [31:0] ia);
        @(posedge clk); #2;
        req_valid = 1'b1; req_kind = k; req_offset = off; rd_bus = rd;
        st_src = src; st_src_is_pc = pc; instr_addr = ia;
        sb.push_back(model(k, off, rd, src, pc, ia));
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2;
        req_valid = 1'b0;
        rd_bus = 32'hDEAD_BEEF; st_src = 32'h1357_9BDF;
        repeat (n) @(posedge clk);
    endtask

    // monitor: samples at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check("R7 unexpected valid", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check({e.tag, " ld_result (R10)"}, ld_result, e.ld);
                        check({e.tag, " wr_bus (R10)"}, wr_bus, e.wr);
                        last_ld = e.ld; last_wr = e.wr;
                    end
                end else if (hold_mode) begin
                    check("R8 hold ld_result", ld_result, last_ld);
                    check("R8 hold wr_bus", wr_bus, last_wr);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        check("R9 reset ld_result", ld_result, 32'd0);
        check("R9 reset wr_bus", wr_bus, 32'd0);
        check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
        @(posedge clk); #2; rst = 1'b0;
        @(posedge clk); #4;
        check("R7 idle valid low", {31'd0, out_valid}, 32'd0);

        // back-to-back stream over all kinds and offsets
        for (int k = 0; k < 4; k++) begin
            for (int o = 0; o < 4; o++) begin
                send(2'(k), 2'(o), 32'hA1B2_C3D4 + 32'(k*16 + o), 32'h8765_43F0 + 32'(o),
                     1'b0, 32'h0000_1000);
            end
        end
        // program-counter stores (R6), including carry into upper bits
        for (int o = 0; o < 4; o++) begin
            send(2'b10, 2'(o), 32'h0, 32'hFFFF_FFFF, 1'b1, 32'h0000_20F8 + 32'(o*4));
            send(2'b11, 2'(o), 32'h0, 32'h5555_5555, 1'b1, 32'h0001_FFF4 + 32'(o*4));
        end
        // interleaved pattern with gaps; R8 hold checked during gaps
        send(2'b01, 2'd3, 32'h0102_0304, 32'h0, 1'b0, 32'h0);
        idle(1);
        @(negedge clk); hold_mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); hold_mode = 1'b0;
        send(2'b11, 2'd1, 32'h0, 32'hCAFE_F00D, 1'b0, 32'h0);
        send(2'b00, 2'd2, 32'h11_22_33_44, 32'h0, 1'b0, 32'h0);
        send(2'b10, 2'd3, 32'h0, 32'h0000_00A5, 1'b0, 32'h0);
        idle(1);
        @(negedge clk); hold_mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); hold_mode = 1'b0;
        // random stream
        for (int i = 0; i < 200; i++) begin
            send(2'($urandom_range(3)), 2'($urandom_range(3)), $urandom, $urandom,
                 1'($urandom_range(1)), $urandom);
        end
        idle(3);
        check("R7 all results delivered", 32'(sb.size()), 32'd0);
        // mid-run reset clears outputs
        send(2'b11, 2'd0, 32'h0, 32'h7777_7777, 1'b0, 32'h0);
        @(posedge clk); #2; req_valid = 1'b0; rst = 1'b1;
        sb.delete();
        @(posedge clk); #4;
        check("R9 mid reset ld_result", ld_result, 32'd0);
        check("R9 mid reset wr_bus", wr_bus, 32'd0);
        check("R9 mid reset out_valid", {31'd0, out_valid}, 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule